// File: doc/BRIEF.md
# Vertical-blank bus copy bridge

This block connects a 16-bit CPU address/data bus to a narrower 14-bit private graphics bus. The graphics bus reaches the display registers and the graphics RAM and ROM. The CPU can reach that bus only while a copy window is open. The window opens on a pulse that marks the start of vertical blank. It closes when the CPU raises its bus-acknowledge line, which normally happens just before active display resumes.

While the window is open, every CPU write is passed to the graphics side with its address and data cut to the low 14 bits. This happens whatever the upper address bits are, so the upper address space holds write-only aliases. Reads are decoded on the full CPU address. A read is answered only when address bits [15:14] are both zero. The answer is registered and comes back one clock after the strobe, with bits [15:14] cleared. Outside the window the graphics strobes stay low and CPU reads get no answer.

Top module: `bus_copy_bridge`

## Requirements
- R1: After reset, `copy_active`, `gfx_rd`, `gfx_wr` and `cpu_rvalid` are all 0, and `cpu_rdata` is 0.
- R2: A `vblank_start` high at a clock edge while `copy_active` is 0 makes `copy_active` 1 after that edge.
- R3: A `bus_ack` high at a clock edge while `copy_active` is 1 makes `copy_active` 0 after that edge. If `vblank_start` is high at the same edge, the exit still happens.
- R4: Some inputs have no effect on the mode. A `bus_ack` while `copy_active` is 0 leaves it at 0. A `vblank_start` while `copy_active` is 1 leaves it at 1.
- R5: While `copy_active` is 0, `gfx_rd` and `gfx_wr` stay 0 for any CPU strobe. A CPU read then leaves `cpu_rvalid` at 0 on the next cycle.
- R6: While `copy_active` is 1, `cpu_wr` gives `gfx_wr`=1 in the same cycle, for any value of address bits [15:14]. In that cycle `gfx_addr` = `cpu_addr[13:0]` and `gfx_wdata` = `cpu_wdata[13:0]`.
- R7: While `copy_active` is 1, a `cpu_rd` with `cpu_addr[15:14]`=00 gives `gfx_rd`=1 and `gfx_addr`=`cpu_addr[13:0]` in the same cycle. After the next edge, `cpu_rvalid`=1 and `cpu_rdata` = {2'b00, `gfx_rdata` as seen in the strobe cycle}.
- R8: While `copy_active` is 1, a `cpu_rd` with `cpu_addr[15:14]` nonzero leaves `gfx_rd` at 0. After the next edge, `cpu_rvalid` is 0 and `cpu_rdata` is 0.
- R9: `cpu_rdata[15:14]` is always 0, and `cpu_rdata` is 0 whenever `cpu_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank_start | input | 1 | Marks the start of vertical blank; opens the copy window |
| bus_ack | input | 1 | CPU bus acknowledge; closes the copy window |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 16 | Returned read data, upper bits zero |
| cpu_rvalid | output | 1 | Read data valid, one clock after an accepted read |
| copy_active | output | 1 | Copy window open |
| gfx_addr | output | 14 | Graphics bus address |
| gfx_wdata | output | 14 | Graphics bus write data |
| gfx_rd | output | 1 | Graphics bus read strobe |
| gfx_wr | output | 1 | Graphics bus write strobe |
| gfx_rdata | input | 14 | Graphics bus read data, valid in the strobe cycle |

## Verification
The graphics strobes, address and write data follow the CPU inputs combinationally. The bench drives each stimulus on the falling edge and samples these outputs 1 ns later, before the next rising edge. Mode changes and read returns pass through one register. The bench therefore samples `copy_active`, `cpu_rvalid` and `cpu_rdata` 1 ns after the rising edge that follows the stimulus. The graphics memory model in the bench answers from `gfx_addr` combinationally. Each expected read value is worked out from the CPU address with the same arithmetic formula, swept over all four upper-bit cases and 64 low addresses.

// File: rtl/bcb_pkg.sv
package bcb_pkg;
   localparam int unsigned CPU_W_DEF = 16;
   localparam int unsigned GFX_W_DEF = 14;

   typedef enum logic {
      MODE_IDLE = 1'b0,
      MODE_COPY = 1'b1
   } bcb_mode_e;
endpackage

// File: rtl/bcb_mode_ctl.sv
module bcb_mode_ctl
   import bcb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic vblank_start,
   input  logic bus_ack,
   output logic copy_active
);
   bcb_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_IDLE: if (vblank_start) mode_d = MODE_COPY;
         MODE_COPY: if (bus_ack)      mode_d = MODE_IDLE;
         default:                     mode_d = MODE_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= MODE_IDLE;
      else        mode_q <= mode_d;
   end

   assign copy_active = (mode_q == MODE_COPY);
endmodule

// File: rtl/bcb_narrow.sv
module bcb_narrow #(
   parameter int unsigned CPU_W = 16,
   parameter int unsigned GFX_W = 14
) (
   input  logic [CPU_W-1:0] cpu_addr,
   input  logic [CPU_W-1:0] cpu_wdata,
   output logic [GFX_W-1:0] nar_addr,
   output logic [GFX_W-1:0] nar_wdata,
   output logic             in_low_window
);
   assign nar_addr  = cpu_addr[GFX_W-1:0];
   assign nar_wdata = cpu_wdata[GFX_W-1:0];

   generate
      if (CPU_W > GFX_W) begin : g_hi
         localparam int unsigned HI_W = CPU_W - GFX_W;
         logic [HI_W-1:0] addr_hi;
         logic [HI_W-1:0] unused_wdata_hi;
         assign addr_hi         = cpu_addr[CPU_W-1:GFX_W];
         assign unused_wdata_hi = cpu_wdata[CPU_W-1:GFX_W];
         assign in_low_window   = (addr_hi == '0);
      end else begin : g_same
         assign in_low_window = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bcb_read_ret.sv
module bcb_read_ret #(
   parameter int unsigned CPU_W = 16,
   parameter int unsigned GFX_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [GFX_W-1:0] gfx_rdata,
   output logic [CPU_W-1:0] cpu_rdata,
   output logic             cpu_rvalid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_rvalid <= 1'b0;
         cpu_rdata  <= '0;
      end else begin
         cpu_rvalid <= take;
         cpu_rdata  <= take ? CPU_W'(gfx_rdata) : '0;
      end
   end
endmodule

// File: rtl/bus_copy_bridge.sv
module bus_copy_bridge #(
   parameter int unsigned CPU_W = bcb_pkg::CPU_W_DEF,
   parameter int unsigned GFX_W = bcb_pkg::GFX_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vblank_start,
   input  logic             bus_ack,
   input  logic [CPU_W-1:0] cpu_addr,
   input  logic [CPU_W-1:0] cpu_wdata,
   input  logic             cpu_rd,
   input  logic             cpu_wr,
   output logic [CPU_W-1:0] cpu_rdata,
   output logic             cpu_rvalid,
   output logic             copy_active,
   output logic [GFX_W-1:0] gfx_addr,
   output logic [GFX_W-1:0] gfx_wdata,
   output logic             gfx_rd,
   output logic             gfx_wr,
   input  logic [GFX_W-1:0] gfx_rdata
);
   generate
      if (GFX_W < 1 || GFX_W > CPU_W) begin : g_bad_width
         $error("bus_copy_bridge: GFX_W must be between 1 and CPU_W");
      end
   endgenerate

   logic in_low;

   bcb_mode_ctl u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .vblank_start (vblank_start),
      .bus_ack      (bus_ack),
      .copy_active  (copy_active)
   );

   bcb_narrow #(.CPU_W(CPU_W), .GFX_W(GFX_W)) u_narrow (
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .nar_addr      (gfx_addr),
      .nar_wdata     (gfx_wdata),
      .in_low_window (in_low)
   );

   assign gfx_wr = copy_active & cpu_wr;
   assign gfx_rd = copy_active & cpu_rd & in_low;

   bcb_read_ret #(.CPU_W(CPU_W), .GFX_W(GFX_W)) u_ret (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (gfx_rd),
      .gfx_rdata  (gfx_rdata),
      .cpu_rdata  (cpu_rdata),
      .cpu_rvalid (cpu_rvalid)
   );
endmodule

// File: rtl/bcb_checker.sv
module bcb_checker #(
   parameter int unsigned CPU_W = 16,
   parameter int unsigned GFX_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vblank_start,
   input logic             bus_ack,
   input logic [CPU_W-1:0] cpu_addr,
   input logic [CPU_W-1:0] cpu_wdata,
   input logic             cpu_rd,
   input logic             cpu_wr,
   input logic [CPU_W-1:0] cpu_rdata,
   input logic             cpu_rvalid,
   input logic             copy_active,
   input logic [GFX_W-1:0] gfx_addr,
   input logic [GFX_W-1:0] gfx_wdata,
   input logic             gfx_rd,
   input logic             gfx_wr,
   input logic [GFX_W-1:0] gfx_rdata
);
   logic hi_set;
   assign hi_set = ((cpu_addr >> GFX_W) != '0);

   p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!copy_active && vblank_start) |=> copy_active);
   p_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_active && bus_ack) |=> !copy_active);
   p_ack_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!copy_active && !vblank_start) |=> !copy_active);
   p_vblank_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_active && !bus_ack) |=> copy_active);
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_active |-> (!gfx_rd && !gfx_wr));
   p_write_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_active && cpu_wr) |-> (gfx_wr && gfx_addr == cpu_addr[GFX_W-1:0]
                                   && gfx_wdata == cpu_wdata[GFX_W-1:0]));
   p_read_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gfx_rd |=> (cpu_rvalid && cpu_rdata == CPU_W'($past(gfx_rdata))));
   p_read_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && hi_set) |-> !gfx_rd);
   p_no_stray_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gfx_rd |=> !cpu_rvalid);
   p_rdata_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_rdata >> GFX_W) == '0) && (cpu_rvalid || cpu_rdata == '0));
endmodule

bind bus_copy_bridge bcb_checker #(.CPU_W(CPU_W), .GFX_W(GFX_W)) u_chk (.*);

// File: tb/tb_bus_copy_bridge.sv
`timescale 1ns/1ps
module tb_bus_copy_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vblank_start = 1'b0, bus_ack = 1'b0;
   logic [15:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [15:0] cpu_rdata;
   logic        cpu_rvalid, copy_active;
   logic [13:0] gfx_addr, gfx_wdata, gfx_rdata;
   logic        gfx_rd, gfx_wr;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // graphics memory model: answers from the address in the same cycle
   assign gfx_rdata = gfx_addr ^ 14'h1B6D;

   bus_copy_bridge dut (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse_mode(input bit vb, input bit ack);
      @(negedge clk); vblank_start = vb; bus_ack = ack;
      @(negedge clk); vblank_start = 1'b0; bus_ack = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d, input bit open);
      @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      #1;
      if (open) begin
         chk(gfx_wr == 1'b1, "R6 gfx_wr", 32'(gfx_wr), 1);
         chk(gfx_addr == a[13:0], "R6 gfx_addr", 32'(gfx_addr), 32'(a[13:0]));
         chk(gfx_wdata == d[13:0], "R6 gfx_wdata", 32'(gfx_wdata), 32'(d[13:0]));
      end else begin
         chk(gfx_wr == 1'b0 && gfx_rd == 1'b0, "R5 write strobe idle", 32'({gfx_rd, gfx_wr}), 0);
      end
      @(posedge clk); #1; cpu_wr = 1'b0;
   endtask

   task automatic do_read(input logic [15:0] a, input bit open);
      logic [15:0] exp_d;
      bit          answer;
      answer = open && (a[15:14] == 2'b00);
      exp_d  = answer ? {2'b00, a[13:0] ^ 14'h1B6D} : 16'h0000;
      @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
      #1;
      if (!open)
         chk(gfx_rd == 1'b0 && gfx_wr == 1'b0, "R5 read strobe idle", 32'({gfx_rd, gfx_wr}), 0);
      else if (answer) begin
         chk(gfx_rd == 1'b1, "R7 gfx_rd", 32'(gfx_rd), 1);
         chk(gfx_addr == a[13:0], "R7 gfx_addr", 32'(gfx_addr), 32'(a[13:0]));
      end else
         chk(gfx_rd == 1'b0, "R8 gfx_rd refused", 32'(gfx_rd), 0);
      @(posedge clk); #1;
      cpu_rd = 1'b0;
      if (answer)
         chk(cpu_rvalid && cpu_rdata == exp_d, "R7 return", 32'({cpu_rvalid, cpu_rdata}), 32'({1'b1, exp_d}));
      else
         chk(!cpu_rvalid && cpu_rdata == 16'h0, open ? "R8 no return" : "R5 no return",
             32'({cpu_rvalid, cpu_rdata}), 0);
      chk(cpu_rdata[15:14] == 2'b00, "R9 upper bits", 32'(cpu_rdata[15:14]), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(!copy_active && !gfx_rd && !gfx_wr && !cpu_rvalid && cpu_rdata == 0, "R1 reset",
          32'({copy_active, gfx_rd, gfx_wr, cpu_rvalid, cpu_rdata}), 0);
      @(negedge clk); rst_n = 1'b1;

      // R4: ack while idle ignored
      @(negedge clk); bus_ack = 1'b1;
      @(posedge clk); #1; chk(!copy_active, "R4 ack idle", 32'(copy_active), 0);
      @(negedge clk); bus_ack = 1'b0;

      // R5: no access outside window
      do_write(16'h0123, 16'hFFFF, 1'b0);
      do_read(16'h0042, 1'b0);

      // R2: open window
      @(negedge clk); vblank_start = 1'b1;
      @(posedge clk); #1; chk(copy_active, "R2 enter", 32'(copy_active), 1);
      @(negedge clk); vblank_start = 1'b0;
      // R4: repeated vblank while open
      @(negedge clk); vblank_start = 1'b1;
      @(posedge clk); #1; chk(copy_active, "R4 vblank open", 32'(copy_active), 1);
      @(negedge clk); vblank_start = 1'b0;

      // R6/R7/R8/R9 sweeps over all upper-bit cases and 64 low addresses
      for (int hi = 0; hi < 4; hi++) begin
         for (int lo = 0; lo < 64; lo++) begin
            logic [15:0] a;
            a = {2'(hi), 14'(lo * 257 + 3)};
            do_write(a, 16'(a * 16'd7 + 16'hC001), 1'b1);
            do_read(a, 1'b1);
         end
      end

      // R3: exit with vblank at the same edge
      @(negedge clk); bus_ack = 1'b1; vblank_start = 1'b1;
      @(posedge clk); #1; chk(!copy_active, "R3 exit", 32'(copy_active), 0);
      @(negedge clk); bus_ack = 1'b0; vblank_start = 1'b0;
      @(posedge clk); #1; chk(!copy_active, "R3 stays closed", 32'(copy_active), 0);
      do_read(16'h0010, 1'b0);

      // reopen and close with plain ack
      pulse_mode(1'b1, 1'b0);
      #1; chk(copy_active, "R2 reopen", 32'(copy_active), 1);
      do_read(16'h3FFF, 1'b1);
      do_read(16'h4000, 1'b1);
      pulse_mode(1'b0, 1'b1);
      #1; chk(!copy_active, "R3 plain exit", 32'(copy_active), 0);
      do_write(16'hC000, 16'h1234, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule